// File: doc/BRIEF.md
# Address Line Alias Tester

This engine looks for broken address wiring between a controller and a word-wide synchronous memory. A broken line is one that is stuck high, stuck low, or shorted to a neighbour. Such a fault makes two different addresses reach the same storage cell. The engine picks a test address and builds partner addresses from it by XOR with a one-hot mask. The mask starts at the first bit above the byte-in-word offset and walks upward until it leaves the address width. For each partner that falls inside the region under test, the engine performs three steps:

1. It reads the partner.
2. It writes the bitwise inverse of that data to the test address.
3. It reads the partner again.

If the second read returns the inverted value, the write reached the partner, so the two addresses alias.

The sweep runs twice. The first pass uses the lowest word of the region as the test address, so a single one walks through zeros. The second pass uses the last word of the region, so a single zero walks through ones. A failing probe does not stop the sweep. Every failure is reported with both addresses and the mask, and the final verdict is given when the engine finishes. Software or a start-up sequencer pulses `start` with the region base and size, then waits for `done`.

Top module: `alias_line_tester`

## Requirements
- R1: During and after reset the block is idle: `busy`, `done`, `pass`, `err_valid`, `mem_rd` and `mem_wr` are all 0. While idle, no memory access is made.
- R2: A `start` pulse while idle captures `region_base` and `region_size`, and `busy` is 1 from the next cycle on. A `start` while busy has no effect on the run.
- R3: Within a pass the mask takes the values WORD_BYTES, 2·WORD_BYTES, … up to bit ADDR_W−1, in rising order, one probe per value. Bits below log2(WORD_BYTES) are never flipped.
- R4: The partner is the test address XOR the mask. A probe is made only when base ≤ partner < base + size. An out-of-range partner causes no memory access at all.
- R5: A probe is exactly this sequence: a read of the partner, a write of the bitwise inverse of that read data to the test address, and a second read of the partner. The test address is never read, and a read and a write never share a cycle.
- R6: A probe fails when the second partner read equals the written inverse. Each failure gives a one-cycle `err_valid` pulse carrying `err_test_addr`, `err_partner_addr` and `err_mask`, where test XOR partner equals the mask.
- R7: The first pass uses test address = base. The second pass uses test address = base + size − WORD_BYTES.
- R8: All probes of both passes run even after a failure. At the end, `done` pulses for one cycle and `busy` is 0. `pass` is 1 only if no probe failed, and it holds until the next accepted start.
- R9: Every memory access is word aligned and lies inside the captured region.
- R10: Read data is taken from `mem_rdata` exactly RD_LAT cycles after the cycle in which `mem_rd` was asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| region_base | input | ADDR_W | Byte address of the first word of the region, word aligned |
| region_size | input | ADDR_W+1 | Region size in bytes, non-zero multiple of the word size |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | Verdict of the last run, 1 = no alias found |
| err_valid | output | 1 | One-cycle pulse per failing probe |
| err_test_addr | output | ADDR_W | Test address of the failing probe |
| err_partner_addr | output | ADDR_W | Partner address of the failing probe |
| err_mask | output | ADDR_W | XOR mask of the failing probe |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid RD_LAT cycles after the request |

## Verification
A stale or corrupted mask shows up on the very next probe: the read addresses leave the expected rising sequence of partners, or a probe is made where the partner lies out of range. A wrong choice of test address or pass shows on the first write of that pass. The bench uses a memory model with injected stuck and shorted address lines. It compares the full order of read and write addresses, each write value against the inverse of the preceding read, and the list of reported failures against a list computed from the fault. A wrong read-latency count corrupts the first inverse written, so it is visible within one probe.

// File: rtl/altest_pkg.sv
package altest_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PROBE,
      ST_WAIT1,
      ST_WRITE,
      ST_READ2,
      ST_WAIT2,
      ST_ADV,
      ST_FIN
   } at_state_e;

endpackage

// File: rtl/altest_probe_gen.sv
module altest_probe_gen #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W:0]   size,
   input  logic              hi_pass,
   input  logic [ADDR_W-1:0] mask,
   output logic [ADDR_W-1:0] test_addr,
   output logic [ADDR_W-1:0] partner,
   output logic              in_range
);
   localparam int WORD_BYTES = DATA_W / 8;

   logic [ADDR_W:0] end_ext;
   logic [ADDR_W:0] top_ext;

   always_comb begin
      end_ext   = {1'b0, base} + size;
      top_ext   = end_ext - (ADDR_W+1)'(WORD_BYTES);
      test_addr = hi_pass ? top_ext[ADDR_W-1:0] : base;
      partner   = test_addr ^ mask;
      in_range  = ({1'b0, partner} >= {1'b0, base}) &&
                  ({1'b0, partner} <  end_ext);
   end

endmodule

// File: rtl/altest_rd_track.sv
module altest_rd_track #(
   parameter int RD_LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_req,
   output logic data_ok
);
   generate
      if (RD_LAT == 1) begin : g_single
         logic v_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) v_q <= 1'b0;
            else        v_q <= rd_req;
         end
         assign data_ok = v_q;
      end else begin : g_chain
         logic [RD_LAT-1:0] v_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) v_q <= '0;
            else        v_q <= {v_q[RD_LAT-2:0], rd_req};
         end
         assign data_ok = v_q[RD_LAT-1];
      end
   endgenerate

endmodule

// File: rtl/altest_seq.sv
module altest_seq
   import altest_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_in,
   input  logic [ADDR_W:0]   size_in,
   input  logic [ADDR_W-1:0] test_addr,
   input  logic [ADDR_W-1:0] partner,
   input  logic              in_range,
   input  logic              data_ok,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] base_q,
   output logic [ADDR_W:0]   size_q,
   output logic              hi_pass,
   output logic [ADDR_W-1:0] mask,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic              err_valid,
   output logic [ADDR_W-1:0] err_test,
   output logic [ADDR_W-1:0] err_partner,
   output logic [ADDR_W-1:0] err_mask
);
   localparam int OFS_W = $clog2(DATA_W / 8);
   localparam logic [ADDR_W-1:0] MASK0 = {{(ADDR_W-1){1'b0}}, 1'b1} << OFS_W;

   at_state_e         state;
   logic [DATA_W-1:0] inv_q;
   logic              fail_seen;
   logic [ADDR_W-1:0] mask_nxt;

   assign mask_nxt  = mask << 1;
   assign busy      = (state != ST_IDLE);
   assign mem_rd    = ((state == ST_PROBE) && in_range) || (state == ST_READ2);
   assign mem_wr    = (state == ST_WRITE);
   assign mem_addr  = (state == ST_WRITE) ? test_addr : partner;
   assign mem_wdata = inv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         base_q      <= '0;
         size_q      <= '0;
         hi_pass     <= 1'b0;
         mask        <= MASK0;
         inv_q       <= '0;
         fail_seen   <= 1'b0;
         done        <= 1'b0;
         pass        <= 1'b0;
         err_valid   <= 1'b0;
         err_test    <= '0;
         err_partner <= '0;
         err_mask    <= '0;
      end else begin
         done      <= 1'b0;
         err_valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  base_q    <= base_in;
                  size_q    <= size_in;
                  hi_pass   <= 1'b0;
                  mask      <= MASK0;
                  fail_seen <= 1'b0;
                  pass      <= 1'b0;
                  state     <= ST_PROBE;
               end
            end
            ST_PROBE: state <= in_range ? ST_WAIT1 : ST_ADV;
            ST_WAIT1: begin
               if (data_ok) begin
                  inv_q <= ~mem_rdata;
                  state <= ST_WRITE;
               end
            end
            ST_WRITE: state <= ST_READ2;
            ST_READ2: state <= ST_WAIT2;
            ST_WAIT2: begin
               if (data_ok) begin
                  if (mem_rdata == inv_q) begin
                     err_valid   <= 1'b1;
                     err_test    <= test_addr;
                     err_partner <= partner;
                     err_mask    <= mask;
                     fail_seen   <= 1'b1;
                  end
                  state <= ST_ADV;
               end
            end
            ST_ADV: begin
               if (mask_nxt != '0) begin
                  mask  <= mask_nxt;
                  state <= ST_PROBE;
               end else if (!hi_pass) begin
                  hi_pass <= 1'b1;
                  mask    <= MASK0;
                  state   <= ST_PROBE;
               end else begin
                  state <= ST_FIN;
               end
            end
            ST_FIN: begin
               done  <= 1'b1;
               pass  <= !fail_seen;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/alias_line_tester.sv
module alias_line_tester #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int RD_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] region_base,
   input  logic [ADDR_W:0]   region_size,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic              err_valid,
   output logic [ADDR_W-1:0] err_test_addr,
   output logic [ADDR_W-1:0] err_partner_addr,
   output logic [ADDR_W-1:0] err_mask,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int WORD_BYTES = DATA_W / 8;
   localparam int OFS_W      = $clog2(WORD_BYTES);

   generate
      if ((DATA_W % 8) != 0 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_width
         $error("DATA_W must be a power-of-two number of bytes");
      end
      if (ADDR_W <= OFS_W) begin : g_bad_addr
         $error("ADDR_W must exceed the byte offset width");
      end
      if (RD_LAT < 1) begin : g_bad_lat
         $error("RD_LAT must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W:0]   size_q;
   logic              hi_pass;
   logic [ADDR_W-1:0] mask;
   logic [ADDR_W-1:0] test_addr;
   logic [ADDR_W-1:0] partner;
   logic              in_range;
   logic              data_ok;

   altest_probe_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gen (
      .base      (base_q),
      .size      (size_q),
      .hi_pass   (hi_pass),
      .mask      (mask),
      .test_addr (test_addr),
      .partner   (partner),
      .in_range  (in_range)
   );

   altest_rd_track #(.RD_LAT(RD_LAT)) u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_req  (mem_rd),
      .data_ok (data_ok)
   );

   altest_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .base_in     (region_base),
      .size_in     (region_size),
      .test_addr   (test_addr),
      .partner     (partner),
      .in_range    (in_range),
      .data_ok     (data_ok),
      .mem_rdata   (mem_rdata),
      .base_q      (base_q),
      .size_q      (size_q),
      .hi_pass     (hi_pass),
      .mask        (mask),
      .mem_rd      (mem_rd),
      .mem_wr      (mem_wr),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .busy        (busy),
      .done        (done),
      .pass        (pass),
      .err_valid   (err_valid),
      .err_test    (err_test_addr),
      .err_partner (err_partner_addr),
      .err_mask    (err_mask)
   );

endmodule

// File: rtl/altest_checker.sv
module altest_checker #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [ADDR_W-1:0] region_base,
   input logic [ADDR_W:0]   region_size,
   input logic              busy,
   input logic              done,
   input logic              pass,
   input logic              err_valid,
   input logic [ADDR_W-1:0] err_test_addr,
   input logic [ADDR_W-1:0] err_partner_addr,
   input logic [ADDR_W-1:0] err_mask,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [ADDR_W-1:0] mem_addr
);
   localparam int OFS_W = $clog2(DATA_W / 8);

   logic [ADDR_W-1:0] cap_base;
   logic [ADDR_W:0]   cap_end;
   logic              err_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_base <= '0;
         cap_end  <= '0;
         err_seen <= 1'b0;
      end else if (start && !busy) begin
         cap_base <= region_base;
         cap_end  <= {1'b0, region_base} + region_size;
         err_seen <= 1'b0;
      end else if (err_valid) begin
         err_seen <= 1'b1;
      end
   end

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_rd && !mem_wr));

   a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   a_r3_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> ($countones(err_mask) == 1 && err_mask[OFS_W-1:0] == '0));

   a_r5_one_access: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   a_r5_reread_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> mem_rd);

   a_r6_pair_relation: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> ((err_test_addr ^ err_partner_addr) == err_mask));

   a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |=> !err_valid);

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && (pass == !err_seen)));

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_in_region: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> (({1'b0, mem_addr} >= {1'b0, cap_base}) &&
                              ({1'b0, mem_addr} < cap_end)));

   a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> (mem_addr[OFS_W-1:0] == '0));

endmodule

bind alias_line_tester altest_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/alias_line_tester_test.sv
module alias_line_tester_test;
   localparam int AW = 12;
   localparam int DW = 32;
   localparam int LAT = 2;
   localparam int WB = DW / 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] region_base = '0;
   logic [AW:0]   region_size = '0;
   logic          busy, done, pass, err_valid, mem_rd, mem_wr;
   logic [AW-1:0] err_test_addr, err_partner_addr, err_mask, mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic [DW-1:0] d1 = '0;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   logic [DW-1:0] mem [0:(1<<AW)/WB-1];
   int fk = 0, fb = 2, fc = 3;

   int nrd, nwr, nerr;
   logic [AW-1:0] rd_log [0:63];
   logic [AW-1:0] wr_log [0:63];
   logic [AW-1:0] et_log [0:31];
   logic [AW-1:0] ep_log [0:31];
   logic [AW-1:0] em_log [0:31];
   logic [DW-1:0] last_rd;

   alias_line_tester #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(LAT)) uut (.*);

   always #2 clk = ~clk;

   function automatic logic [AW-1:0] phys(input logic [AW-1:0] a);
      logic [AW-1:0] r;
      logic x;
      r = a;
      case (fk)
         1: r[fb] = 1'b0;
         2: r[fb] = 1'b1;
         3: begin x = r[fb] | r[fc]; r[fb] = x; r[fc] = x; end
         default: ;
      endcase
      return r;
   endfunction

   always @(posedge clk) begin
      if (mem_wr) mem[phys(mem_addr) >> 2] <= mem_wdata;
      d1        <= mem[phys(mem_addr) >> 2];
      mem_rdata <= d1;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (rst_n && mem_rd) begin
         if (nrd < 64) rd_log[nrd] = mem_addr;
         nrd++;
         last_rd = mem[phys(mem_addr) >> 2];
      end
      if (rst_n && mem_wr) begin
         if (nwr < 64) wr_log[nwr] = mem_addr;
         nwr++;
         chk(mem_wdata == ~last_rd, "R5 R10", "write data is inverse of partner read",
             longint'(mem_wdata), longint'(~last_rd));
      end
      if (rst_n && err_valid) begin
         if (nerr < 32) begin
            et_log[nerr] = err_test_addr;
            ep_log[nerr] = err_partner_addr;
            em_log[nerr] = err_mask;
         end
         nerr++;
      end
      if (cycles > 190000) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=%0d expected<190000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic run_case(input int base, input int size, input int kind,
                           input int b1, input int b2);
      logic [AW-1:0] xt [0:31];
      logic [AW-1:0] xp [0:31];
      logic [AW-1:0] xm [0:31];
      bit            xe [0:31];
      int np, ne, wait_cyc, ei;
      logic [AW-1:0] t, p;
      fk = kind; fb = b1; fc = b2;
      np = 0; ne = 0;
      for (int ps = 0; ps < 2; ps++) begin
         t = (ps == 0) ? AW'(base) : AW'(base + size - WB);
         for (int b = 2; b < AW; b++) begin
            p = t ^ (AW'(1) << b);
            if (int'(p) >= base && int'(p) < base + size) begin
               xt[np] = t; xp[np] = p; xm[np] = AW'(1) << b;
               xe[np] = (phys(p) == phys(t));
               if (xe[np]) ne++;
               np++;
            end
         end
      end
      for (int i = 0; i < (1<<AW)/WB; i++) mem[i] = $urandom;
      @(negedge clk);
      nrd = 0; nwr = 0; nerr = 0;
      region_base = AW'(base);
      region_size = (AW+1)'(size);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2", "busy after start", longint'(busy), 1);
      @(negedge clk);
      region_base = AW'(base ^ 12'h800);
      region_size = (AW+1)'(WB);
      start = busy;
      @(negedge clk);
      start = 1'b0;
      wait_cyc = 0;
      while (!done && wait_cyc < 4000) begin
         @(negedge clk);
         wait_cyc++;
      end
      chk(done == 1'b1, "R8", "run finished", longint'(done), 1);
      chk(busy == 1'b0, "R8", "idle at done", longint'(busy), 0);
      chk(pass == (ne == 0), "R8", "verdict", longint'(pass), longint'(ne == 0));
      chk(nrd == 2 * np, "R4", "read count", nrd, 2 * np);
      chk(nwr == np, "R4", "write count", nwr, np);
      chk(nerr == ne, "R6", "failure count", nerr, ne);
      if (nrd == 2 * np && nwr == np) begin
         ei = 0;
         for (int i = 0; i < np; i++) begin
            chk(rd_log[2*i] == xp[i] && rd_log[2*i+1] == xp[i], "R3 R9",
                "partner read order", longint'(rd_log[2*i]), longint'(xp[i]));
            chk(wr_log[i] == xt[i], "R7", "test address of write",
                longint'(wr_log[i]), longint'(xt[i]));
            if (xe[i] && ei < nerr && ei < 32) begin
               chk(et_log[ei] == xt[i] && ep_log[ei] == xp[i] && em_log[ei] == xm[i],
                   "R6", "failure report", longint'(ep_log[ei]), longint'(xp[i]));
               ei++;
            end
         end
      end
      @(negedge clk);
      chk(done == 1'b0 && pass == (ne == 0), "R8", "done pulse and held verdict",
          longint'({done, pass}), longint'(ne == 0));
   endtask

   initial begin
      int base, size, kind, b1, b2;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0 && pass == 0 && err_valid == 0 && mem_rd == 0 && mem_wr == 0,
          "R1", "reset outputs", longint'({busy, done, pass, err_valid, mem_rd, mem_wr}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(busy == 0 && mem_rd == 0 && mem_wr == 0, "R1", "idle after reset",
          longint'({busy, mem_rd, mem_wr}), 0);
      run_case(0, 4096, 0, 2, 3);
      run_case(12'h200, 12'h400, 0, 2, 3);
      run_case(12'h100, WB, 0, 2, 3);
      run_case(0, 4096, 1, 5, 3);
      run_case(0, 4096, 2, 11, 3);
      run_case(12'h040, 12'hF00, 3, 7, 9);
      run_case(12'h800, 12'h800, 3, 2, 10);
      for (int n = 0; n < 10; n++) begin
         base = int'($urandom % 1024) * WB;
         size = (int'($urandom % (1024 - base / WB)) + 1) * WB;
         kind = int'($urandom % 4);
         b1 = 2 + int'($urandom % 10);
         b2 = 2 + int'((b1 - 2 + 1 + ($urandom % 9)) % 10);
         run_case(base, size, kind, b1, b2);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule